// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt events from twelve on-chip sources of a small 8-bit processor core and turns them into a single request line and a vector address. Each source has its own sticky pending flag. A flag can reach the priority logic only if its enable bit is set. The enable bits sit in two byte-wide registers. A fixed-priority encoder chooses one enabled pending source, and a global interrupt enable (GIE) decides whether that choice is offered to the core.

The core signals acknowledge at an instruction boundary. At that moment the block does three things. It clears GIE, clears the pending flag of the winning source only, and registers the vector address for that source. The vector is a fixed base plus twice the source index, which gives each source a two-byte jump slot.

The core drives three single-cycle command strobes that act on GIE: disable, enable and return-from-interrupt. A status byte shows GIE. It also shows a sense flag, which is set whenever an enabled source is pending, even while GIE is off. Firmware can also drop pending flags directly through two write-one-to-clear registers.

Top module: `pvic_top`

## Requirements
- R1: A synchronous reset clears every pending flag, every enable bit and GIE. After reset, the registers at 0x20, 0x21 and 0x3F read 0x00 and `irq_req` is low.
- R2: A high `src_set[i]` in a cycle sets pending flag i. The flag stays set until firmware clears it or an acknowledge services it. Bit 7 of the status register (0x3F) reads 1 whenever any enabled source is pending, whether or not GIE is set.
- R3: Register 0x20 bits 7:0 enable sources 0 to 7. Register 0x21 bits 3:0 enable sources 8 to 11, and its bits 7:4 read 0. A pending source whose enable bit is clear does not affect `irq_req` or the sense bit. Setting its enable bit later makes it visible.
- R4: `irq_req` is combinational and equals GIE AND (any enabled source pending).
- R5: Priority is fixed. Among enabled pending sources, the lowest index wins: source 0 (bus reset) is highest and source 11 (serial bus) is lowest.
- R6: An `irq_ack` taken while `irq_req` is high has these effects on the next cycle. `vec_addr` equals VEC_BASE + 2*index (0x010 + 2*index by default), and `vec_valid` is high for exactly one cycle. GIE is 0. Only the winning source's flag is cleared.
- R7: The winner is decided in the acknowledge cycle itself. A higher-priority source that latched after `irq_req` rose is the one that gets vectored.
- R8: `cmd_di` clears GIE, and `cmd_ei` or `cmd_reti` sets it. When disable and enable come in the same cycle, disable wins. A taken acknowledge clears GIE even if an enable command arrives in the same cycle.
- R9: GIE reads back at bit 2 of the status register (0x3F). The other status bits, except bit 7, read 0.
- R10: Writing 1s to 0x22 (bits 7:0 map to sources 0 to 7) or to 0x23 (bits 3:0 map to sources 8 to 11) clears those pending flags. A set event in the same cycle wins over a firmware clear, and also over an acknowledge clear of the same source.
- R11: An `irq_ack` while `irq_req` is low is ignored. `vec_valid` stays low, and GIE and all pending flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set | input | 12 | Per-source event strobes, one bit per source index |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr`, one cycle later |
| cmd_ei | input | 1 | Enable-interrupts command strobe |
| cmd_di | input | 1 | Disable-interrupts command strobe |
| cmd_reti | input | 1 | Return-from-interrupt strobe, sets GIE |
| irq_req | output | 1 | Interrupt request to the core |
| irq_ack | input | 1 | Acknowledge from the core at an instruction boundary |
| vec_addr | output | 12 | Vector address registered at acknowledge |
| vec_valid | output | 1 | One-cycle pulse marking a fresh vector |

## Verification
Two functions can act on one pending flag in the same cycle: a source event can arrive in the very cycle that clears the flag. The clear comes either from a firmware write to a clear register or from an acknowledge that services that source. The bench drives both collisions on purpose. It pulses `src_set` together with a clear-register write, and together with `irq_ack` while that source is the winner. It then judges the result through the status sense bit, and expects the flag to survive in both cases. In the same way, disable and enable strobes collide with each other and with a taken acknowledge, and the bench checks the outcome through the GIE status bit.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int STAT_GIE_BIT   = 2;
  localparam int STAT_SENSE_BIT = 7;
  localparam int REG_BYTE       = 8;

  function automatic logic [15:0] widen16(input logic [15:0] v);
    return v;
  endfunction
endpackage

// File: rtl/pvic_latch_bank.sv
module pvic_latch_bank #(
  parameter int N_SRC = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] fw_clr_i,
  input  logic [N_SRC-1:0] ack_clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        pend_q[i] <= 1'b0;
      else if (set_i[i])
        pend_q[i] <= 1'b1;
      else if (fw_clr_i[i] || ack_clr_i[i])
        pend_q[i] <= 1'b0;
    end

    // R10: an event beats any clear in the same cycle
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> pend_o[i]);
    // R2: a flag is sticky while nothing clears it
    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
      (pend_o[i] && !fw_clr_i[i] && !ack_clr_i[i]) |=> pend_o[i]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pvic_prio_enc.sv
module pvic_prio_enc #(
  parameter int N_SRC = 12,
  localparam int IW   = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [IW-1:0]    idx_o,
  output logic [N_SRC-1:0] grant_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
    grant_o = '0;
    if (any_o) grant_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/pvic_gie.sv
module pvic_gie (
  input  logic clk,
  input  logic rst,
  input  logic take_i,
  input  logic di_i,
  input  logic ei_i,
  input  logic reti_i,
  output logic gie_o
);
  logic gie_q;

  always_ff @(posedge clk) begin
    if (rst)
      gie_q <= 1'b0;
    else if (take_i || di_i)
      gie_q <= 1'b0;
    else if (ei_i || reti_i)
      gie_q <= 1'b1;
  end

  assign gie_o = gie_q;

  a_r6_ack_drops_gie: assert property (@(posedge clk) disable iff (rst)
    take_i |=> !gie_o);
  a_r8_di_drops_gie: assert property (@(posedge clk) disable iff (rst)
    di_i |=> !gie_o);
  a_r8_ei_raises_gie: assert property (@(posedge clk) disable iff (rst)
    ((ei_i || reti_i) && !di_i && !take_i) |=> gie_o);
endmodule

// File: rtl/pvic_top.sv
module pvic_top #(
  parameter int          N_SRC      = 12,
  parameter int          AW         = 8,
  parameter int          VW         = 12,
  parameter logic [11:0] VEC_BASE   = 12'h010,
  parameter logic [7:0]  A_EN_LO    = 8'h20,
  parameter logic [7:0]  A_EN_HI    = 8'h21,
  parameter logic [7:0]  A_CLR_LO   = 8'h22,
  parameter logic [7:0]  A_CLR_HI   = 8'h23,
  parameter logic [7:0]  A_STAT     = 8'h3F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_set,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             cmd_ei,
  input  logic             cmd_di,
  input  logic             cmd_reti,
  output logic             irq_req,
  input  logic             irq_ack,
  output logic [VW-1:0]    vec_addr,
  output logic             vec_valid
);
  import pvic_pkg::*;

  localparam int IW = $clog2(N_SRC);
  localparam int LO_N = (N_SRC < REG_BYTE) ? N_SRC : REG_BYTE;

  logic [N_SRC-1:0] en_q, pend, masked, grant, fw_clr, ack_clr;
  logic [IW-1:0]    win_idx;
  logic             any_hit, gie, take, sense;
  logic             wr_en_lo, wr_en_hi, wr_clr_lo, wr_clr_hi;
  logic [15:0]      wd16, en16;
  logic [VW-1:0]    vec_q;
  logic             vld_q;
  logic [7:0]       rd_q;

  assign wr_en_lo  = reg_wr && (reg_addr == AW'(A_EN_LO));
  assign wr_en_hi  = reg_wr && (reg_addr == AW'(A_EN_HI));
  assign wr_clr_lo = reg_wr && (reg_addr == AW'(A_CLR_LO));
  assign wr_clr_hi = reg_wr && (reg_addr == AW'(A_CLR_HI));
  assign wd16      = widen16({reg_wdata, reg_wdata});

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (i < LO_N) begin : g_lo
      assign fw_clr[i] = wr_clr_lo && wd16[i];
      always_ff @(posedge clk) begin
        if (rst)           en_q[i] <= 1'b0;
        else if (wr_en_lo) en_q[i] <= wd16[i];
      end
    end else begin : g_hi
      assign fw_clr[i] = wr_clr_hi && wd16[i];
      always_ff @(posedge clk) begin
        if (rst)           en_q[i] <= 1'b0;
        else if (wr_en_hi) en_q[i] <= wd16[i];
      end
    end
  end

  pvic_latch_bank #(.N_SRC(N_SRC)) u_bank (
    .clk(clk), .rst(rst), .set_i(src_set), .fw_clr_i(fw_clr),
    .ack_clr_i(ack_clr), .pend_o(pend)
  );

  assign masked = pend & en_q;

  pvic_prio_enc #(.N_SRC(N_SRC)) u_enc (
    .req_i(masked), .any_o(any_hit), .idx_o(win_idx), .grant_o(grant)
  );

  assign sense   = any_hit;
  assign irq_req = gie && any_hit;
  assign take    = irq_ack && irq_req;
  assign ack_clr = take ? grant : '0;

  pvic_gie u_gie (
    .clk(clk), .rst(rst), .take_i(take), .di_i(cmd_di),
    .ei_i(cmd_ei), .reti_i(cmd_reti), .gie_o(gie)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= take;
      if (take) vec_q <= VW'(VEC_BASE) + (VW'(win_idx) << 1);
    end
  end

  always_comb begin
    en16 = '0;
    en16[N_SRC-1:0] = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      rd_q <= '0;
      if (reg_addr == AW'(A_EN_LO))      rd_q <= en16[7:0];
      else if (reg_addr == AW'(A_EN_HI)) rd_q <= en16[15:8];
      else if (reg_addr == AW'(A_STAT)) begin
        rd_q[STAT_SENSE_BIT] <= sense;
        rd_q[STAT_GIE_BIT]   <= gie;
      end
    end
  end

  assign reg_rdata = rd_q;
  assign vec_addr  = vec_q;
  assign vec_valid = vld_q;

  a_r4_req_needs_gie: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> gie);
  a_r5_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (any_hit == (grant != '0)));
  a_r6_vld_pulse: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);
  a_r6_vec_in_range: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_addr >= VW'(VEC_BASE)) &&
                  (vec_addr <= VW'(VEC_BASE) + VW'(2 * (N_SRC - 1))) &&
                  (vec_addr[0] == VEC_BASE[0]));
  a_r11_idle_ack: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !irq_req) |=> !vec_valid);
endmodule

// File: tb/tb_pvic_top.sv
module tb_pvic_top;
  localparam int N = 12;
  localparam int BASE = 16;

  logic clk = 0, rst = 1;
  logic [N-1:0] src_set = '0;
  logic reg_wr = 0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic cmd_ei = 0, cmd_di = 0, cmd_reti = 0, irq_ack = 0;
  logic irq_req, vec_valid;
  logic [11:0] vec_addr;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pvic_top dut (
    .clk(clk), .rst(rst), .src_set(src_set), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_ei(cmd_ei), .cmd_di(cmd_di), .cmd_reti(cmd_reti),
    .irq_req(irq_req), .irq_ack(irq_ack), .vec_addr(vec_addr),
    .vec_valid(vec_valid)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    reg_addr = a; tick(); v = int'(reg_rdata);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    src_set = m; tick(); src_set = '0;
  endtask

  task automatic ei();   cmd_ei = 1;   tick(); cmd_ei = 0;   endtask
  task automatic di();   cmd_di = 1;   tick(); cmd_di = 0;   endtask
  task automatic ack();  irq_ack = 1;  tick(); irq_ack = 0;  endtask

  task automatic do_reset();
    rst = 1; src_set = '0; reg_wr = 0; cmd_ei = 0; cmd_di = 0;
    cmd_reti = 0; irq_ack = 0;
    tick(); tick(); rst = 0; tick();
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    rd(8'h20, v); chk("R1 en_lo", v, 0);
    rd(8'h21, v); chk("R1 en_hi", v, 0);
    rd(8'h3F, v); chk("R1 status", v, 0);
    chk("R1 irq_req", int'(irq_req), 0);
  endtask

  task automatic t_enable_sense();
    int v;
    do_reset();
    pulse(12'h008);
    rd(8'h3F, v); chk("R3 disabled pending hidden", v, 0);
    wr(8'h20, 8'h08);
    rd(8'h3F, v); chk("R2 sense with GIE off", v, 'h80);
    chk("R4 req low while GIE off", int'(irq_req), 0);
    repeat (5) tick();
    rd(8'h3F, v); chk("R2 flag sticky", v, 'h80);
    wr(8'h21, 8'hFF);
    rd(8'h21, v); chk("R3 en_hi upper bits zero", v, 'h0F);
  endtask

  task automatic t_gie_cmds();
    int v;
    do_reset();
    pulse(12'h004); wr(8'h20, 8'h04);
    ei();
    rd(8'h3F, v); chk("R9 status GIE bit2 and sense", v, 'h84);
    chk("R4 req high", int'(irq_req), 1);
    di();
    chk("R8 DI drops req", int'(irq_req), 0);
    cmd_ei = 1; cmd_di = 1; tick(); cmd_ei = 0; cmd_di = 0;
    rd(8'h3F, v); chk("R8 DI beats EI", v, 'h80);
    cmd_reti = 1; tick(); cmd_reti = 0;
    rd(8'h3F, v); chk("R8 RETI sets GIE", v, 'h84);
  endtask

  task automatic t_priority();
    int v;
    do_reset();
    wr(8'h20, 8'hFF); wr(8'h21, 8'h0F);
    pulse(12'hA20);
    ei(); ack();
    chk("R6 vld", int'(vec_valid), 1);
    chk("R5 vec src5", int'(vec_addr), BASE + 10);
    chk("R6 GIE cleared", int'(irq_req), 0);
    tick();
    chk("R6 vld one cycle", int'(vec_valid), 0);
    rd(8'h3F, v); chk("R6 others still pending", v, 'h80);
    ei(); ack();
    chk("R5 vec src9", int'(vec_addr), BASE + 18);
    ei(); ack();
    chk("R5 vec src11", int'(vec_addr), BASE + 22);
    rd(8'h3F, v); chk("R6 all serviced", v, 0);
  endtask

  task automatic t_late_winner();
    do_reset();
    wr(8'h20, 8'hFF);
    pulse(12'h080); ei();
    chk("R4 req for src7", int'(irq_req), 1);
    pulse(12'h002);
    ack();
    chk("R7 late higher source vectored", int'(vec_addr), BASE + 2);
  endtask

  task automatic t_idle_ack();
    int v;
    do_reset();
    wr(8'h20, 8'h01); pulse(12'h001);
    ack();
    chk("R11 no vector with GIE off", int'(vec_valid), 0);
    rd(8'h3F, v); chk("R11 pending kept", v, 'h80);
    wr(8'h22, 8'h01); ei();
    ack();
    chk("R11 no vector when nothing pending", int'(vec_valid), 0);
    rd(8'h3F, v); chk("R11 GIE kept", v, 'h04);
  endtask

  task automatic t_clear_races();
    int v;
    do_reset();
    wr(8'h20, 8'hFF); wr(8'h21, 8'h0F);
    pulse(12'h010);
    wr(8'h22, 8'h10);
    rd(8'h3F, v); chk("R10 fw clear", v, 0);
    pulse(12'h400);
    wr(8'h23, 8'h04);
    rd(8'h3F, v); chk("R10 fw clear hi", v, 0);
    reg_wr = 1; reg_addr = 8'h22; reg_wdata = 8'h10; src_set = 12'h010;
    tick(); reg_wr = 0; src_set = '0;
    rd(8'h3F, v); chk("R10 set beats fw clear", v, 'h80);
    wr(8'h22, 8'h10);
    pulse(12'h004); ei();
    irq_ack = 1; src_set = 12'h004; cmd_ei = 1;
    tick(); irq_ack = 0; src_set = '0; cmd_ei = 0;
    chk("R6 vec src2", int'(vec_addr), BASE + 4);
    rd(8'h3F, v); chk("R10 set beats ack clear, R8 ack beats EI", v, 'h80);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_enable_sense();
    t_gie_cmds();
    t_priority();
    t_late_winner();
    t_idle_ack();
    t_clear_races();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule